// File: doc/BRIEF.md
# Manchester Bus Word Transmitter

This block is the serialising end of a 1 Mbit/s Manchester II bi-phase serial bus, clocked at 32 MHz. A controller hands it a 16-bit word together with a flag that says whether the word is a data word or a command/status word. The block then sends one complete frame on the line:

- a three-bit-time sync pattern whose polarity depends on the word type;
- the sixteen payload bits, each coded bi-phase;
- a computed odd-parity bit.

The line appears as a complementary pair of levels together with a transmit enable. All three are low whenever nothing is being sent.

The controller raises `load` with the word and type on the inputs. An idle block takes the word on the next clock edge. While a frame is going out, `busy` stays high. `done` marks the final clock cycle of each frame. If `load` is high in that cycle, the next word is taken at once and its sync starts in the very next cycle, so words run back to back with no idle time between them. At any other moment during a frame, `load` is ignored.

Top module: `mbus_word_tx`

## Requirements
- R1: After reset, and before any word is loaded, `busy`, `done`, `tx_en`, `line_p` and `line_n` are all 0.
- R2: While `tx_en` is 0, both `line_p` and `line_n` are 0. While `tx_en` is 1, `line_n` is the inverse of `line_p`.
- R3: A frame is 40 half-bit slots of 16 clock cycles each, 640 cycles in total. `line_p` changes only at slot boundaries. Slot 0 begins in the cycle after the edge that takes the word.
- R4: Slots 0-2 carry the sync's first part and slots 3-5 its second part. For a command/status word (`is_data`=0) the sync is high then low. For a data word (`is_data`=1) it is low then high.
- R5: Slots 6 to 37 carry `word_in[15]` down to `word_in[0]`, most significant bit first, two slots per bit. A 1 is sent high then low, and a 0 is sent low then high.
- R6: Slots 38-39 carry a parity bit, coded the same way as a data bit. The parity bit makes the number of ones across the 16 payload bits and the parity bit odd.
- R7: `busy` is 1 for all 640 cycles of a frame. `done` is 1 only in the last cycle of the frame.
- R8: If `load` is 1 in the cycle where `done` is 1, the next word's slot 0 starts in the following cycle, and `busy` and `tx_en` stay high. If `load` is 0 in that cycle, the block goes idle in the following cycle.
- R9: A `load` pulse during a frame, in any cycle other than the `done` cycle, has no effect on the line or on the frame's timing.
- R10: `word_in` and `is_data` are sampled only when a word is taken. Later changes do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Request to send the word on `word_in` |
| word_in | input | 16 | Payload word |
| is_data | input | 1 | 1: data-word sync, 0: command/status sync |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Last cycle of the current frame |
| tx_en | output | 1 | Line driver enable |
| line_p | output | 1 | True line level |
| line_n | output | 1 | Complementary line level |

## Verification
The embedded properties assume a clean synchronous reset. They also assume that `load` is a plain level: it is either taken or ignored, depending only on whether the block is idle or in its final cycle. Nothing is assumed about when `load` arrives or what `word_in` holds at other times.

The stimulus changes `load`, `word_in` and `is_data` only at falling clock edges. It deliberately pulses `load` in the middle of frames and scrambles the payload inputs while a frame is in flight. It chains words with `load` held high through the final cycle, and it also lets the block fall idle between frames.

// File: rtl/mbus_word_tx.sv
module mbus_word_tx #(
  parameter int HALF_CYC = 16,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_in,
  input  logic         is_data,
  output logic         busy,
  output logic         done,
  output logic         tx_en,
  output logic         line_p,
  output logic         line_n
);

  localparam int NHALF = 6 + 2 * (W + 1);
  localparam int HW = $clog2(NHALF);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          active, typ;
  logic [HW-1:0] hidx;
  logic [CW-1:0] cnt;
  logic [W:0]    sr;
  logic          level;

  wire half_end = (cnt == CW'(HALF_CYC - 1));
  wire last     = active && half_end && (hidx == HW'(NHALF - 1));
  wire take     = load && (!active || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      typ    <= 1'b0;
      hidx   <= '0;
      cnt    <= '0;
      sr     <= '0;
    end else if (take) begin
      active <= 1'b1;
      typ    <= is_data;
      hidx   <= '0;
      cnt    <= '0;
      sr     <= {word_in, ~^word_in};
    end else if (last) begin
      active <= 1'b0;
      hidx   <= '0;
      cnt    <= '0;
    end else if (active) begin
      if (half_end) begin
        cnt  <= '0;
        hidx <= hidx + HW'(1);
        if (hidx >= HW'(7) && hidx[0])
          sr <= {sr[W-1:0], 1'b0};
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    if (hidx < HW'(3))      level = ~typ;
    else if (hidx < HW'(6)) level = typ;
    else                    level = sr[W] ^ hidx[0];
  end

  assign busy   = active;
  assign done   = last;
  assign tx_en  = active;
  assign line_p = active & level;
  assign line_n = active & ~level;

  // R3
  half_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !half_end && !last) |=> $stable(line_p));

  // R4
  sync_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hidx == HW'(3) && cnt == '0) |-> (line_p != $past(line_p)));

  // R5
  midbit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hidx >= HW'(7) && hidx[0] && cnt == '0) |-> (line_p != $past(line_p)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && load) |=> (tx_en && hidx == '0 && cnt == '0));

  // R8
  idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (!tx_en && !line_p && !line_n));

  // R2
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!line_p && !line_n));

  // R10
  type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> $stable(typ));

endmodule

// File: tb/mbus_word_tx_tb_top.sv
module mbus_word_tx_tb_top;
  localparam int CLK_P = 10;
  localparam int FRAME = 640;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, is_data = 1'b0;
  logic [15:0] word_in = '0;
  logic busy, done, tx_en, line_p, line_n;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mbus_word_tx dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(word_in), .is_data(is_data),
    .busy(busy), .done(done), .tx_en(tx_en), .line_p(line_p), .line_n(line_n)
  );

  function automatic bit exp_lvl(input logic [15:0] w, input bit dt, input int k);
    int h, b;
    bit bv;
    int ones;
    h = k / 16;
    if (h < 3) return !dt;
    if (h < 6) return dt;
    b = (h - 6) / 2;
    if (b < 16) bv = w[15-b];
    else begin
      ones = 0;
      for (int i = 0; i < 16; i++) ones += w[i];
      bv = (ones % 2 == 0);
    end
    return (h % 2 == 0) ? bv : !bv;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check(!busy && !done && !tx_en && !line_p && !line_n, req,
          {busy, done, tx_en, line_p, line_n}, 0);
  endtask

  // Called at a falling edge inside cycle 0 of a frame.
  task automatic play(input logic [15:0] w, input bit dt, input bit chain,
                      input logic [15:0] nw, input bit ndt, input int poke);
    bit e;
    for (int k = 0; k < FRAME; k++) begin
      e = exp_lvl(w, dt, k);
      // R3 R4 R5 R6 R9 R10
      check(line_p == e, k < 96 ? "R4" : (k >= 608 ? "R6" : "R5"), line_p, e);
      // R2
      check(tx_en && line_n == !line_p, "R2", {tx_en, line_n}, {1'b1, !e});
      // R7
      check(busy && done == (k == FRAME - 1), "R7", {busy, done}, {1'b1, k == FRAME - 1});
      if (poke >= 0 && k == poke) begin
        load = 1'b1; word_in = ~w; is_data = !dt;
      end else if (poke >= 0 && k == poke + 1) begin
        load = 1'b0;
      end else if (k % 37 == 5) begin
        word_in = 16'($urandom); is_data = 1'($urandom);
      end
      if (k == FRAME - 1 && chain) begin
        load = 1'b1; word_in = nw; is_data = ndt;
      end
      @(negedge clk);
      if (k == FRAME - 1 && chain) load = 1'b0;
    end
    // R8
    if (!chain) check_idle("R8");
    else check(busy && tx_en && line_p == exp_lvl(nw, ndt, 0), "R8", line_p, exp_lvl(nw, ndt, 0));
  endtask

  task automatic start(input logic [15:0] w, input bit dt);
    load = 1'b1; word_in = w; is_data = dt;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] cw, nw;
    bit cd, nd, ch;
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    // R1
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    start(16'h0000, 1'b0);
    play(16'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 200);
    repeat (3) @(negedge clk);
    check_idle("R2");

    start(16'hFFFF, 1'b1);
    play(16'hFFFF, 1'b1, 1'b1, 16'h8001, 1'b0, 50);
    play(16'h8001, 1'b0, 1'b1, 16'hA5A5, 1'b1, 638);
    play(16'hA5A5, 1'b1, 1'b0, 16'h0, 1'b0, -1);
    @(negedge clk);

    cw = 16'($urandom); cd = 1'($urandom);
    start(cw, cd);
    for (int n = 0; n < 8; n++) begin
      nw = 16'($urandom); nd = 1'($urandom); ch = (n < 7) ? 1'($urandom) : 1'b0;
      play(cw, cd, ch, nw, nd, int'($urandom_range(0, 600)));
      if (!ch && n < 7) begin
        repeat (int'($urandom_range(1, 5))) @(negedge clk);
        start(nw, nd);
      end
      cw = nw; cd = nd;
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule